// File: doc/BRIEF.md
# Control-endpoint standard request handler

This block sits beside the control endpoint of a full- or high-speed USB device. It takes each 8-byte setup packet once the packet has been received and decodes it. A fixed group of standard requests is answered entirely in hardware: configuration select and query, interface select and query, halt and un-halt of an endpoint, enabling and disabling remote wake-up, and address assignment. Any other request, or one whose direction or recipient does not fit, raises a single flag that tells firmware to handle it.

The handler holds the device state these requests change. That state is a one-bit configuration (0 or 1), the 7-bit device address, one halt bit per endpoint and the remote wake-up enable. The configuration decides which endpoints are enabled. A query returns one byte on a valid/ready response stream. An illegal value produces STALL on the control endpoint. Each handled request that changes state leaves a bit in a write-one-to-clear event register, and that register drives an interrupt.

Setup packets enter on a valid/ready stream. `setup_ready` is low while a response byte waits to be taken, so a new setup packet is held back until the consumer has accepted the pending byte. `rsp_valid` and `rsp_data` stay unchanged until `rsp_ready` is seen high. A bus reset drops any pending byte.

Top module: `stdreq_engine`

## Requirements
- R1: After `rst_n` low or a `bus_reset` pulse, the outputs are as follows: `cfg_active` is 0, `dev_addr` is 0, `ep_halt` and `wake_en` are 0, no response is pending, and `ep_enable` is 1 for endpoint 0 only. Endpoint numbers are limited to `NUM_EP` ≤ 16.
- R2: A set-configuration request (byte0 0x00, byte1 0x09) with value 1 sets `cfg_active`, and with value 0 clears it. When the configuration is 1, `ep_enable` has every bit set. When it is 0, only bit 0 is set.
- R3: A set-configuration request whose 16-bit value (bytes 2–3, little-endian) is above 1 raises `ep0_stall` and leaves the configuration unchanged. `ep0_stall` is updated on every accepted setup packet, so the next legal or firmware-routed request clears it.
- R4: A get-configuration request (0x80, 0x08) returns one byte equal to the current configuration. A get-interface request (0x81, 0x0A) returns the byte 0. While a byte is pending, `setup_ready` is low and `rsp_data` holds its value.
- R5: Event bits are laid out as follows: bit0 configuration set, bit1 halt set, bit2 halt cleared, bit3 wake-up enabled, bit4 wake-up disabled, bit5 interface set. Set-address, get-configuration, get-interface and stalled requests leave `evt_flags` unchanged. `irq` is high whenever any event bit is set.
- R6: Set-feature (0x02, 0x03) and clear-feature (0x02, 0x01) with feature value 0 set or clear the halt bit of the endpoint given by bits 3:0 of the index (bytes 4–5). The direction bit 7 of the index is ignored. A clear also pulses that endpoint's bit of `toggle_clr` for the one cycle after acceptance. An endpoint number ≥ `NUM_EP` raises `ep0_stall` instead.
- R7: Set-feature and clear-feature to the device (0x00, codes 0x03 and 0x01) with feature value 1 set and clear `wake_en`.
- R8: Set-address (0x00, 0x05) with a value ≤ 127 does not change `dev_addr` until the next `status_done` pulse. At that pulse it loads the new value. A value above 127 stalls.
- R9: Any other request reaches firmware through `fw_setup`. That includes a known request code sent with the wrong direction, type or recipient. Such a request changes no device state, produces no response and no stall. `fw_setup` stays set until `fw_setup_clr` is pulsed.
- R10: Writing a 1 on `evt_clr` clears that event bit. If the same bit is being set in the same cycle, it stays set.
- R11: Set-interface (0x01, 0x0B) with alternate setting 0 records event bit5. A nonzero setting stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| bus_reset | input | 1 | Detected USB bus reset, one or more cycles |
| setup_valid | input | 1 | Setup packet present |
| setup_ready | output | 1 | Handler can take a setup packet |
| setup_data | input | 64 | Setup packet, byte0 in bits 7:0 |
| status_done | input | 1 | Status stage of the current control transfer finished |
| rsp_valid | output | 1 | Response byte present |
| rsp_ready | input | 1 | Consumer takes the response byte |
| rsp_data | output | 8 | Response byte |
| ep0_stall | output | 1 | Control endpoint answers STALL |
| cfg_active | output | 1 | Current configuration (0 or 1) |
| dev_addr | output | 7 | Device address in force |
| ep_enable | output | NUM_EP | Endpoint enables |
| ep_halt | output | NUM_EP | Endpoint halt state |
| toggle_clr | output | NUM_EP | One-cycle data-toggle reset per endpoint |
| wake_en | output | 1 | Remote wake-up enabled |
| evt_flags | output | 6 | Handled-request event register |
| evt_clr | input | 6 | Write-one-to-clear for evt_flags |
| irq | output | 1 | Event interrupt |
| fw_setup | output | 1 | Request needs firmware |
| fw_setup_clr | input | 1 | Clears fw_setup |

## Verification
Two functions can act on the same event bit in one cycle. These are the acceptance of a handled request, which sets an event bit, and firmware's write-one-to-clear on that bit. The bench drives a set-configuration packet and an `evt_clr` of bit0 in the same cycle and expects bit0 to read 1 afterwards; a clear with no concurrent request must then read 0. A second overlap concerns the response stream: a query arriving while the consumer stalls `rsp_ready` must hold `setup_ready` low with the byte unchanged until it is taken.

// File: rtl/stdreq_pkg.sv
package stdreq_pkg;

  // Request classes recognised by the decoder
  typedef enum logic [3:0] {
    RQ_NONE,
    RQ_SET_CFG,
    RQ_GET_CFG,
    RQ_SET_HALT,
    RQ_CLR_HALT,
    RQ_SET_WAKE,
    RQ_CLR_WAKE,
    RQ_GET_INTF,
    RQ_SET_INTF,
    RQ_SET_ADDR
  } req_kind_e;

  typedef struct packed {
    req_kind_e   kind;
    logic [15:0] value;
    logic [15:0] index;
  } req_t;

  // Event register layout
  localparam int EVT_N       = 6;
  localparam int EV_CFG      = 0;
  localparam int EV_HALT_SET = 1;
  localparam int EV_HALT_CLR = 2;
  localparam int EV_WAKE_SET = 3;
  localparam int EV_WAKE_CLR = 4;
  localparam int EV_INTF     = 5;

  // Standard request codes
  localparam logic [7:0] CODE_CLR_FEAT = 8'h01;
  localparam logic [7:0] CODE_SET_FEAT = 8'h03;
  localparam logic [7:0] CODE_SET_ADDR = 8'h05;
  localparam logic [7:0] CODE_GET_CFG  = 8'h08;
  localparam logic [7:0] CODE_SET_CFG  = 8'h09;
  localparam logic [7:0] CODE_GET_INTF = 8'h0A;
  localparam logic [7:0] CODE_SET_INTF = 8'h0B;

  // Request-type bytes: direction, type (standard), recipient
  localparam logic [7:0] RT_OUT_DEV  = 8'h00;
  localparam logic [7:0] RT_OUT_INTF = 8'h01;
  localparam logic [7:0] RT_OUT_EP   = 8'h02;
  localparam logic [7:0] RT_IN_DEV   = 8'h80;
  localparam logic [7:0] RT_IN_INTF  = 8'h81;

  // Feature selectors
  localparam logic [15:0] FEAT_HALT = 16'd0;
  localparam logic [15:0] FEAT_WAKE = 16'd1;

endpackage

// File: rtl/stdreq_decode.sv
module stdreq_decode
  import stdreq_pkg::*;
(
  input  logic [63:0] setup,
  output req_t        req
);

  logic [7:0]  rtype;
  logic [7:0]  code;
  logic [15:0] val;
  logic [15:0] idx;

  assign rtype = setup[7:0];
  assign code  = setup[15:8];
  assign val   = setup[31:16];
  assign idx   = setup[47:32];

  always_comb begin
    req.kind  = RQ_NONE;
    req.value = val;
    req.index = idx;
    case (code)
      CODE_SET_CFG:  if (rtype == RT_OUT_DEV)  req.kind = RQ_SET_CFG;
      CODE_GET_CFG:  if (rtype == RT_IN_DEV)   req.kind = RQ_GET_CFG;
      CODE_GET_INTF: if (rtype == RT_IN_INTF)  req.kind = RQ_GET_INTF;
      CODE_SET_INTF: if (rtype == RT_OUT_INTF) req.kind = RQ_SET_INTF;
      CODE_SET_ADDR: if (rtype == RT_OUT_DEV)  req.kind = RQ_SET_ADDR;
      CODE_SET_FEAT: begin
        if (rtype == RT_OUT_EP && val == FEAT_HALT)       req.kind = RQ_SET_HALT;
        else if (rtype == RT_OUT_DEV && val == FEAT_WAKE) req.kind = RQ_SET_WAKE;
      end
      CODE_CLR_FEAT: begin
        if (rtype == RT_OUT_EP && val == FEAT_HALT)       req.kind = RQ_CLR_HALT;
        else if (rtype == RT_OUT_DEV && val == FEAT_WAKE) req.kind = RQ_CLR_WAKE;
      end
      default: req.kind = RQ_NONE;
    endcase
  end

endmodule

// File: rtl/stdreq_ctrl.sv
module stdreq_ctrl
  import stdreq_pkg::*;
#(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              accept,
  input  req_t              req,
  input  logic              status_done,
  output logic              cfg_q,
  output logic [6:0]        addr_q,
  output logic [NUM_EP-1:0] halt_q,
  output logic [NUM_EP-1:0] tog_q,
  output logic              wake_q,
  output logic              stall_q,
  output logic [EVT_N-1:0]  evt_set,
  output logic              fw_req
);

  logic [3:0] ep_num;
  logic       ep_ok;
  logic       bad;
  logic       good;
  logic       pend_q;
  logic [6:0] pend_addr_q;

  assign ep_num = req.index[3:0];
  assign ep_ok  = int'(ep_num) < NUM_EP;

  // Legality of the accepted request
  always_comb begin
    bad = 1'b0;
    case (req.kind)
      RQ_SET_CFG:               bad = req.value > 16'd1;
      RQ_SET_HALT, RQ_CLR_HALT: bad = !ep_ok;
      RQ_SET_ADDR:              bad = req.value > 16'd127;
      RQ_SET_INTF:              bad = req.value != 16'd0;
      default:                  bad = 1'b0;
    endcase
  end

  assign good   = accept && !bad && (req.kind != RQ_NONE);
  assign fw_req = accept && (req.kind == RQ_NONE);

  always_comb begin
    evt_set = '0;
    if (good) begin
      case (req.kind)
        RQ_SET_CFG:  evt_set[EV_CFG]      = 1'b1;
        RQ_SET_HALT: evt_set[EV_HALT_SET] = 1'b1;
        RQ_CLR_HALT: evt_set[EV_HALT_CLR] = 1'b1;
        RQ_SET_WAKE: evt_set[EV_WAKE_SET] = 1'b1;
        RQ_CLR_WAKE: evt_set[EV_WAKE_CLR] = 1'b1;
        RQ_SET_INTF: evt_set[EV_INTF]     = 1'b1;
        default:     evt_set = '0;
      endcase
    end
  end

  // Device-wide state
  always_ff @(posedge clk) begin
    if (!rst_n || bus_reset) begin
      cfg_q       <= 1'b0;
      addr_q      <= '0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      wake_q      <= 1'b0;
      stall_q     <= 1'b0;
    end else begin
      if (status_done && pend_q) begin
        addr_q <= pend_addr_q;
        pend_q <= 1'b0;
      end
      if (accept) begin
        stall_q <= bad;
        if (good) begin
          case (req.kind)
            RQ_SET_CFG:  cfg_q  <= req.value[0];
            RQ_SET_WAKE: wake_q <= 1'b1;
            RQ_CLR_WAKE: wake_q <= 1'b0;
            RQ_SET_ADDR: begin
              pend_q      <= 1'b1;
              pend_addr_q <= req.value[6:0];
            end
            default: ;
          endcase
        end
      end
    end
  end

  // Per-endpoint halt and toggle reset
  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic hit;
    logic halt_r;
    logic tog_r;

    assign hit = good && (ep_num == 4'(i));

    always_ff @(posedge clk) begin
      if (!rst_n || bus_reset) begin
        halt_r <= 1'b0;
        tog_r  <= 1'b0;
      end else begin
        tog_r <= hit && (req.kind == RQ_CLR_HALT);
        if (hit && req.kind == RQ_SET_HALT)      halt_r <= 1'b1;
        else if (hit && req.kind == RQ_CLR_HALT) halt_r <= 1'b0;
      end
    end

    assign halt_q[i] = halt_r;
    assign tog_q[i]  = tog_r;
  end

endmodule

// File: rtl/stdreq_status.sv
module stdreq_status #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         fw_set,
  input  logic         fw_clr,
  output logic [N-1:0] flags_q,
  output logic         fw_q,
  output logic         irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      fw_q    <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_i) | set_i;
      fw_q    <= fw_set | (fw_q & ~fw_clr);
    end
  end

  assign irq = |flags_q;

endmodule

// File: rtl/stdreq_engine.sv
module stdreq_engine
  import stdreq_pkg::*;
#(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              setup_valid,
  output logic              setup_ready,
  input  logic [63:0]       setup_data,
  input  logic              status_done,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic              ep0_stall,
  output logic              cfg_active,
  output logic [6:0]        dev_addr,
  output logic [NUM_EP-1:0] ep_enable,
  output logic [NUM_EP-1:0] ep_halt,
  output logic [NUM_EP-1:0] toggle_clr,
  output logic              wake_en,
  output logic [5:0]        evt_flags,
  input  logic [5:0]        evt_clr,
  output logic              irq,
  output logic              fw_setup,
  input  logic              fw_setup_clr
);

  req_t              req;
  logic              accept;
  logic [EVT_N-1:0]  evt_set;
  logic              fw_req;
  logic              rsp_v_q;
  logic [7:0]        rsp_d_q;

  assign setup_ready = !rsp_v_q;
  assign accept      = setup_valid && setup_ready;

  stdreq_decode u_dec (
    .setup (setup_data),
    .req   (req)
  );

  stdreq_ctrl #(.NUM_EP(NUM_EP)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_reset   (bus_reset),
    .accept      (accept),
    .req         (req),
    .status_done (status_done),
    .cfg_q       (cfg_active),
    .addr_q      (dev_addr),
    .halt_q      (ep_halt),
    .tog_q       (toggle_clr),
    .wake_q      (wake_en),
    .stall_q     (ep0_stall),
    .evt_set     (evt_set),
    .fw_req      (fw_req)
  );

  stdreq_status #(.N(EVT_N)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (evt_set),
    .clr_i   (evt_clr),
    .fw_set  (fw_req),
    .fw_clr  (fw_setup_clr),
    .flags_q (evt_flags),
    .fw_q    (fw_setup),
    .irq     (irq)
  );

  // Response byte register
  always_ff @(posedge clk) begin
    if (!rst_n || bus_reset) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else if (accept && req.kind == RQ_GET_CFG) begin
      rsp_v_q <= 1'b1;
      rsp_d_q <= {7'b0, cfg_active};
    end else if (accept && req.kind == RQ_GET_INTF) begin
      rsp_v_q <= 1'b1;
      rsp_d_q <= 8'h00;
    end else if (rsp_v_q && rsp_ready) begin
      rsp_v_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_d_q;

  // Configuration gates the endpoint enables
  assign ep_enable[0] = 1'b1;
  for (genvar i = 1; i < NUM_EP; i++) begin : g_en
    assign ep_enable[i] = cfg_active;
  end

endmodule

// File: rtl/stdreq_checker.sv
module stdreq_checker #(
  parameter int NUM_EP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_reset,
  input logic              setup_ready,
  input logic              status_done,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [7:0]        rsp_data,
  input logic              ep0_stall,
  input logic              cfg_active,
  input logic [6:0]        dev_addr,
  input logic [NUM_EP-1:0] ep_enable,
  input logic [NUM_EP-1:0] ep_halt,
  input logic [NUM_EP-1:0] toggle_clr,
  input logic              fw_setup
);

  AST_BUS_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!cfg_active && dev_addr == 7'd0 && ep_halt == '0)); // R1

  AST_CFG0_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_active |-> (ep_enable == NUM_EP'(1))); // R2

  AST_RSP_BLOCKS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !setup_ready); // R4

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !bus_reset) |=> (rsp_valid && $stable(rsp_data))); // R4

  AST_TOGGLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(toggle_clr)); // R6

  AST_TOGGLE_UNHALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (|toggle_clr) |-> ((ep_halt & toggle_clr) == '0)); // R6

  AST_ADDR_WAITS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_done && !bus_reset) |=> $stable(dev_addr)); // R8

  AST_FW_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fw_setup) |-> !ep0_stall); // R9

endmodule

bind stdreq_engine stdreq_checker #(.NUM_EP(NUM_EP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_reset   (bus_reset),
  .setup_ready (setup_ready),
  .status_done (status_done),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .ep0_stall   (ep0_stall),
  .cfg_active  (cfg_active),
  .dev_addr    (dev_addr),
  .ep_enable   (ep_enable),
  .ep_halt     (ep_halt),
  .toggle_clr  (toggle_clr),
  .fw_setup    (fw_setup)
);

// File: tb/sim_stdreq_engine.sv
module sim_stdreq_engine;

  localparam int NEP = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_reset = 1'b0;
  logic           setup_valid = 1'b0;
  logic           setup_ready;
  logic [63:0]    setup_data = '0;
  logic           status_done = 1'b0;
  logic           rsp_valid;
  logic           rsp_ready = 1'b1;
  logic [7:0]     rsp_data;
  logic           ep0_stall;
  logic           cfg_active;
  logic [6:0]     dev_addr;
  logic [NEP-1:0] ep_enable;
  logic [NEP-1:0] ep_halt;
  logic [NEP-1:0] toggle_clr;
  logic           wake_en;
  logic [5:0]     evt_flags;
  logic [5:0]     evt_clr = '0;
  logic           irq;
  logic           fw_setup;
  logic           fw_setup_clr = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] expq[$];

  always #5 clk = ~clk;

  stdreq_engine #(.NUM_EP(NEP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .setup_valid(setup_valid), .setup_ready(setup_ready), .setup_data(setup_data),
    .status_done(status_done), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .ep0_stall(ep0_stall), .cfg_active(cfg_active),
    .dev_addr(dev_addr), .ep_enable(ep_enable), .ep_halt(ep_halt),
    .toggle_clr(toggle_clr), .wake_en(wake_en), .evt_flags(evt_flags),
    .evt_clr(evt_clr), .irq(irq), .fw_setup(fw_setup), .fw_setup_clr(fw_setup_clr)
  );

  function automatic logic [63:0] pkt(input logic [7:0] rt, input logic [7:0] code,
                                      input logic [15:0] val, input logic [15:0] idx);
    return {16'd0, idx, val, code, rt};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: waits for ready, presents one packet, records the expected reply
  task automatic send(input logic [63:0] p, input logic [5:0] clr,
                      input bit has_rsp, input logic [7:0] expv);
    @(negedge clk);
    while (!setup_ready) @(negedge clk);
    setup_data  = p;
    setup_valid = 1'b1;
    evt_clr     = clr;
    if (has_rsp) expq.push_back(expv);
    @(negedge clk);
    setup_valid = 1'b0;
    evt_clr     = '0;
  endtask

  task automatic pulse_clr(input logic [5:0] m);
    @(negedge clk);
    evt_clr = m;
    @(negedge clk);
    evt_clr = '0;
  endtask

  // Monitor: compares each transferred response byte with the queue head
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rsp_valid && rsp_ready) begin
        if (expq.size() == 0) chk("R4 unexpected response", 32'(rsp_data), 32'hFFFF);
        else chk("R4 response byte", 32'(rsp_data), 32'(expq.pop_front()));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg", 32'(cfg_active), 0);
    chk("R1 addr", 32'(dev_addr), 0);
    chk("R1 enable", 32'(ep_enable), 1);
    chk("R1 halt", 32'(ep_halt), 0);
    chk("R1 ready", 32'(setup_ready), 1);
    chk("R5 flags at reset", 32'(evt_flags), 0);

    send(pkt(8'h80, 8'h08, 0, 0), 0, 1, 8'h00);            // R4 get config = 0
    send(pkt(8'h00, 8'h09, 1, 0), 0, 0, 0);                // R2 set config 1
    chk("R2 cfg", 32'(cfg_active), 1);
    chk("R2 enable", 32'(ep_enable), 32'hF);
    chk("R5 cfg event", 32'(evt_flags), 1);
    chk("R5 irq", 32'(irq), 1);
    send(pkt(8'h80, 8'h08, 0, 0), 0, 1, 8'h01);            // R4 get config = 1
    send(pkt(8'h00, 8'h09, 2, 0), 0, 0, 0);                // R3 illegal config
    chk("R3 stall", 32'(ep0_stall), 1);
    chk("R3 cfg kept", 32'(cfg_active), 1);
    chk("R5 stalled no event", 32'(evt_flags), 1);
    send(pkt(8'h81, 8'h0A, 0, 0), 0, 1, 8'h00);            // R4 get interface = 0
    chk("R3 stall cleared", 32'(ep0_stall), 0);
    chk("R5 get intf no event", 32'(evt_flags), 1);
    pulse_clr(6'h01);
    chk("R10 cleared", 32'(evt_flags), 0);
    chk("R5 irq low", 32'(irq), 0);

    send(pkt(8'h02, 8'h03, 0, 16'h0082), 0, 0, 0);         // R6 halt ep2 (IN)
    chk("R6 halt set", 32'(ep_halt), 4);
    chk("R5 halt event", 32'(evt_flags), 2);
    send(pkt(8'h02, 8'h01, 0, 16'h0002), 0, 0, 0);         // R6 clear halt ep2
    chk("R6 toggle pulse", 32'(toggle_clr), 4);
    chk("R6 halt cleared", 32'(ep_halt), 0);
    @(negedge clk);
    chk("R6 toggle one cycle", 32'(toggle_clr), 0);
    send(pkt(8'h02, 8'h03, 0, 16'h0005), 0, 0, 0);         // R6 ep out of range
    chk("R6 bad ep stall", 32'(ep0_stall), 1);
    chk("R6 bad ep no halt", 32'(ep_halt), 0);

    send(pkt(8'h00, 8'h03, 1, 0), 0, 0, 0);                // R7 wake on
    chk("R7 wake set", 32'(wake_en), 1);
    send(pkt(8'h00, 8'h01, 1, 0), 0, 0, 0);                // R7 wake off
    chk("R7 wake clear", 32'(wake_en), 0);
    chk("R5 wake events", 32'(evt_flags), 32'h1E);
    pulse_clr(6'h3F);

    send(pkt(8'h00, 8'h05, 16'h2A, 0), 0, 0, 0);           // R8 set address
    chk("R8 addr deferred", 32'(dev_addr), 0);
    chk("R5 addr no event", 32'(evt_flags), 0);
    repeat (2) @(negedge clk);
    chk("R8 addr still deferred", 32'(dev_addr), 0);
    status_done = 1'b1;
    @(negedge clk);
    status_done = 1'b0;
    chk("R8 addr applied", 32'(dev_addr), 32'h2A);
    send(pkt(8'h00, 8'h05, 16'h0080, 0), 0, 0, 0);         // R8 address too large
    chk("R8 big addr stall", 32'(ep0_stall), 1);

    send(pkt(8'h80, 8'h06, 16'h0100, 0), 0, 0, 0);         // R9 descriptor request
    chk("R9 fw flag", 32'(fw_setup), 1);
    chk("R9 no stall", 32'(ep0_stall), 0);
    @(negedge clk);
    fw_setup_clr = 1'b1;
    @(negedge clk);
    fw_setup_clr = 1'b0;
    chk("R9 fw cleared", 32'(fw_setup), 0);
    send(pkt(8'h01, 8'h09, 0, 0), 0, 0, 0);                // R9 wrong recipient
    chk("R9 mismatch to fw", 32'(fw_setup), 1);
    chk("R9 cfg untouched", 32'(cfg_active), 1);
    chk("R9 no event", 32'(evt_flags), 0);

    send(pkt(8'h01, 8'h0B, 0, 0), 0, 0, 0);                // R11 alt 0
    chk("R11 intf event", 32'(evt_flags), 32'h20);
    send(pkt(8'h01, 8'h0B, 1, 0), 0, 0, 0);                // R11 alt 1
    chk("R11 alt stall", 32'(ep0_stall), 1);
    pulse_clr(6'h3F);

    send(pkt(8'h00, 8'h09, 1, 0), 0, 0, 0);
    send(pkt(8'h00, 8'h09, 1, 0), 6'h01, 0, 0);            // R10 set wins over clear
    chk("R10 set wins", 32'(evt_flags), 1);
    pulse_clr(6'h01);
    chk("R10 plain clear", 32'(evt_flags), 0);

    rsp_ready = 1'b0;                                      // R4 back-pressure
    send(pkt(8'h81, 8'h0A, 0, 0), 0, 1, 8'h00);
    repeat (3) @(negedge clk);
    chk("R4 held valid", 32'(rsp_valid), 1);
    chk("R4 setup blocked", 32'(setup_ready), 0);
    rsp_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 drained", 32'(rsp_valid), 0);

    send(pkt(8'h02, 8'h03, 0, 16'h0001), 0, 0, 0);
    send(pkt(8'h00, 8'h03, 1, 0), 0, 0, 0);
    @(negedge clk);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    chk("R1 bus reset cfg", 32'(cfg_active), 0);
    chk("R1 bus reset addr", 32'(dev_addr), 0);
    chk("R1 bus reset halt", 32'(ep_halt), 0);
    chk("R1 bus reset wake", 32'(wake_en), 0);
    chk("R1 bus reset enable", 32'(ep_enable), 1);

    repeat (3) @(negedge clk);
    chk("R4 all responses seen", 32'(expq.size()), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule